// File: doc/BRIEF.md
# Run-Length Hysteresis Detector

This block watches a single serial bit, taking one sample on each clock edge where the step enable is high. Its output turns on only after the input has been 1 for a set number of samples in a row, eight by default. Once on, the output stays on until the input has been 0 for a smaller set number of samples in a row, four by default. Because the two thresholds differ, a noisy input cannot make the output chatter. In the intended use, the serial bit comes from a switch and the step comes from a push button. Debouncing and synchronisation of those inputs are handled outside the block.

The machine has `ON_RUN + OFF_RUN` explicitly coded states, twelve by default, held in a 4-bit register. Codes 0 to `ON_RUN-1` count the run of ones while the output is low. Codes `ON_RUN` upward count the run of zeros while the output is high. A broken run restarts only the count that is in progress. Any unused code returns to 0 on the next step. The main output is Mealy style: it depends on the current state and the current input bit. A registered copy of it is also provided for driving an indicator.

Top module: `rld_fsm`

## Requirements
- R1: While rst_ni is low, and on release from reset, the machine is in its all-zero state: det_q_o is 0, and det_o is 0 for either value of bit_i.
- R2: While the output is off, det_o is 1 exactly when bit_i is 1 and the previous ON_RUN-1 steps (default 7) all sampled a 1. On that step the machine turns on.
- R3: While the output is off, a step that samples 0 clears the ones count. ON_RUN fresh consecutive 1 steps are then needed to turn on.
- R4: While the output is on, det_o stays 1 until the step on which bit_i is 0 and the previous OFF_RUN-1 steps (default 3) all sampled 0. On that step det_o is 0 and the machine turns off.
- R5: While the output is on, a step that samples 1 clears the zeros count and keeps the output on.
- R6: A clock edge with step_i low changes neither the state nor det_q_o.
- R7: After each clock edge with step_i high, det_q_o equals the value det_o had just before that edge.
- R8: From reset, with default parameters, the step sequence 0,1,0,1,1,1,1,1,1,1,1,1,0,0,0,0 gives det_o = 0 for the first ten samples, 1 for the next five, and 0 for the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Step enable; the input is sampled and the state advances only when high |
| bit_i | input | 1 | Serial input sample |
| det_o | output | 1 | Mealy detector output, from the current state and bit_i |
| det_q_o | output | 1 | det_o registered on each enabled step |

## Verification
The bench sweeps runs of ones from zero to eleven long, each ended by a zero. This catches an off-by-one threshold, which would turn on at seven or nine ones, and a design that keeps counting across a broken run. It then sweeps runs of zeros from zero to five long, each ended by a one. A design that does not re-arm the zeros count on a 1 would turn off early, and a wrong exit step would drop the output at three or five zeros. A long pseudo-random stretch with many disabled steps checks that idle edges leave both the state and the registered copy unchanged. A model kept only as two run counters predicts every sample.

// File: rtl/rld_pkg.sv
package rld_pkg;
  localparam int unsigned DEF_ON_RUN  = 8;
  localparam int unsigned DEF_OFF_RUN = 4;

  typedef struct packed {
    logic legal;      // code inside the used range
    logic high_side;  // output-on half of the code space
    logic last_low;   // final ones-count code
    logic last_high;  // final zeros-count code
  } dec_t;
endpackage

// File: rtl/rld_decode.sv
module rld_decode #(
  parameter int unsigned ON_RUN  = rld_pkg::DEF_ON_RUN,
  parameter int unsigned OFF_RUN = rld_pkg::DEF_OFF_RUN,
  parameter int unsigned ST_W    = $clog2(ON_RUN + OFF_RUN)
) (
  input  logic [ST_W-1:0] state_i,
  output rld_pkg::dec_t   dec_o
);
  localparam int unsigned NUM_ST = ON_RUN + OFF_RUN;
  localparam logic [ST_W-1:0] HI_BASE  = ST_W'(ON_RUN);
  localparam logic [ST_W-1:0] LO_LAST  = ST_W'(ON_RUN - 1);
  localparam logic [ST_W-1:0] MAX_CODE = ST_W'(NUM_ST - 1);

  always_comb begin
    dec_o.legal     = (state_i <= MAX_CODE);
    dec_o.high_side = dec_o.legal && (state_i >= HI_BASE);
    dec_o.last_low  = (state_i == LO_LAST);
    dec_o.last_high = (state_i == MAX_CODE);
  end
endmodule

// File: rtl/rld_next.sv
module rld_next #(
  parameter int unsigned ON_RUN  = rld_pkg::DEF_ON_RUN,
  parameter int unsigned OFF_RUN = rld_pkg::DEF_OFF_RUN,
  parameter int unsigned ST_W    = $clog2(ON_RUN + OFF_RUN)
) (
  input  logic [ST_W-1:0] state_i,
  input  rld_pkg::dec_t   dec_i,
  input  logic            bit_i,
  output logic [ST_W-1:0] next_o
);
  localparam logic [ST_W-1:0] HI_BASE = ST_W'(ON_RUN);
  localparam logic [ST_W-1:0] ONE     = ST_W'(1);

  always_comb begin
    if (!dec_i.legal) begin
      next_o = '0;  // unused codes recover
    end else if (!dec_i.high_side) begin
      if (!bit_i)             next_o = '0;
      else if (dec_i.last_low) next_o = HI_BASE;
      else                    next_o = state_i + ONE;
    end else begin
      if (bit_i)               next_o = HI_BASE;
      else if (dec_i.last_high) next_o = '0;
      else                     next_o = state_i + ONE;
    end
  end
endmodule

// File: rtl/rld_state_reg.sv
module rld_state_reg #(
  parameter int unsigned ST_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [ST_W-1:0] d_i,
  output logic [ST_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/rld_fsm.sv
module rld_fsm #(
  parameter int unsigned ON_RUN  = rld_pkg::DEF_ON_RUN,
  parameter int unsigned OFF_RUN = rld_pkg::DEF_OFF_RUN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic bit_i,
  output logic det_o,
  output logic det_q_o
);
  localparam int unsigned NUM_ST = ON_RUN + OFF_RUN;
  localparam int unsigned ST_W   = $clog2(NUM_ST);
  localparam logic [ST_W-1:0] HI_BASE  = ST_W'(ON_RUN);
  localparam logic [ST_W-1:0] MAX_CODE = ST_W'(NUM_ST - 1);

  logic [ST_W-1:0] state_q, state_d;
  rld_pkg::dec_t   dec;

  rld_decode #(.ON_RUN(ON_RUN), .OFF_RUN(OFF_RUN), .ST_W(ST_W)) u_decode (
    .state_i (state_q),
    .dec_o   (dec)
  );

  rld_next #(.ON_RUN(ON_RUN), .OFF_RUN(OFF_RUN), .ST_W(ST_W)) u_next (
    .state_i (state_q),
    .dec_i   (dec),
    .bit_i   (bit_i),
    .next_o  (state_d)
  );

  rld_state_reg #(.ST_W(ST_W)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (step_i),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  // Mealy output: on while in the high half unless this is the final zero
  always_comb begin
    if (dec.high_side) det_o = ~(dec.last_high & ~bit_i);
    else               det_o = dec.legal & dec.last_low & bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      det_q_o <= 1'b0;
    else if (step_i)  det_q_o <= det_o;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(state_q) && $stable(det_q_o))); // R6
  AST_LOW_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !bit_i && !dec.high_side) |=> (state_q == '0)); // R3
  AST_TURN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && det_o && !dec.high_side) |=> (state_q == HI_BASE)); // R2
  AST_HIGH_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && bit_i && dec.high_side) |=> (state_q == HI_BASE && det_o)); // R5
  AST_TURN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !det_o && dec.high_side) |=> (state_q == '0)); // R4
  AST_REG_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (det_q_o == $past(det_o))); // R7
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q <= MAX_CODE); // R1
endmodule

// File: tb/rld_fsm_bench.sv
module rld_fsm_bench;
  localparam int ON_RUN  = 8;
  localparam int OFF_RUN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic bit_in = 1'b0;
  logic det, det_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model
  bit m_on = 1'b0;
  int m_ones = 0;
  int m_zeros = 0;
  bit m_q = 1'b0;

  always #10 clk = ~clk;

  rld_fsm #(.ON_RUN(ON_RUN), .OFF_RUN(OFF_RUN)) u_rld_fsm (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .step_i  (step),
    .bit_i   (bit_in),
    .det_o   (det),
    .det_q_o (det_q)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_det(input bit b);
    if (m_on) return !(!b && m_zeros == OFF_RUN - 1);
    return b && m_ones == ON_RUN - 1;
  endfunction

  function automatic string model_tag(input bit b, input bit s);
    if (!s) return "R6";
    if (m_on) return (!b && m_zeros == OFF_RUN - 1) ? "R4" : "R5";
    return (b && m_ones == ON_RUN - 1) ? "R2" : "R3";
  endfunction

  task automatic model_step(input bit b);
    if (!m_on) begin
      if (b) begin
        m_ones++;
        if (m_ones == ON_RUN) begin m_on = 1'b1; m_zeros = 0; end
      end else m_ones = 0;
    end else begin
      if (!b) begin
        m_zeros++;
        if (m_zeros == OFF_RUN) begin m_on = 1'b0; m_ones = 0; end
      end else m_zeros = 0;
    end
  endtask

  task automatic cycle(input bit b, input bit s);
    bit exp_d;
    @(negedge clk);
    bit_in = b;
    step = s;
    #5;
    exp_d = model_det(b);
    check(model_tag(b, s), det, exp_d);
    @(posedge clk);
    #1;
    if (s) begin
      m_q = exp_d;
      model_step(b);
    end
    check(s ? "R7" : "R6", det_q, m_q);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step = 1'b1;
    bit_in = 1'b1;
    #2;
    check("R1", det_q, 1'b0);
    check("R1", det, 1'b0);
    bit_in = 1'b0;
    #2;
    check("R1", det, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    m_on = 1'b0; m_ones = 0; m_zeros = 0; m_q = 1'b0;
    #2;
    check("R1", det_q, 1'b0);
  endtask

  initial begin
    logic [15:0] lfsr;
    bit ex_in [16] = '{0,1,0,1,1,1,1,1,1,1,1,1,0,0,0,0};
    bit ex_out[16] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,1,1,0};
    do_reset();

    // R8 worked example
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      bit_in = ex_in[i];
      step = 1'b1;
      #5;
      check("R8", det, ex_out[i]);
      @(posedge clk);
      #1;
      m_q = model_det(ex_in[i]);
      model_step(ex_in[i]);
    end

    // R2/R3: ones-run sweep, each run ended by a zero
    do_reset();
    for (int k = 0; k <= 11; k++) begin
      for (int j = 0; j < OFF_RUN; j++) cycle(1'b0, 1'b1);
      for (int j = 0; j < k; j++) cycle(1'b1, 1'b1);
      cycle(1'b0, 1'b1);
    end

    // R4/R5: zeros-run sweep while on
    for (int z = 0; z <= 5; z++) begin
      for (int j = 0; j < ON_RUN; j++) cycle(1'b1, 1'b1);
      for (int j = 0; j < z; j++) cycle(1'b0, 1'b1);
      cycle(1'b1, 1'b1);
      for (int j = 0; j < OFF_RUN; j++) cycle(1'b0, 1'b1);
    end

    // R6/R7: pseudo-random runs with idle edges
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      bit b, s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if ((n / 200) % 2 == 0) b = (lfsr[3:0] != 4'h0);
      else                    b = (lfsr[3:0] == 4'h0);
      s = (lfsr[7:6] != 2'b00);
      cycle(b, s);
    end

    // R6: idle edges while one short of turning on
    do_reset();
    for (int j = 0; j < ON_RUN - 1; j++) cycle(1'b1, 1'b1);
    for (int j = 0; j < 5; j++) cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule